// File: doc/BRIEF.md
# Image Encoder Control Register Bank

This block is the host-facing register slave of an image compression core. It sits on a simple 32-bit peripheral bus with select, read-not-write, address, byte enables and separate read and write data paths. It answers every single-word access with a one-cycle acknowledge. The host reaches four things through it:

- a control word that carries the colour component count and a start bit;
- a packed image-size word;
- a 64-entry table of 8-bit quantization values;
- a status word that it polls until the frame is finished.

Towards the core, the block drives a one-cycle start strobe and the latched component count, width and height. It also offers a combinational lookup port into the quantization table. The core answers with a done pulse, which moves the status to finished.

Top module: `encRegBank`

## Requirements
- R1: `busAck` goes high for exactly one cycle, in the cycle after the first clock edge that samples `busSel` high. It does not go high again while `busSel` stays high, only after `busSel` has been sampled low.
- R2: `busRdata` carries the read value only in the cycle when `busAck` is high for a read, and is zero in every other cycle.
- R3: The control word sits at byte address 0x0. A write stores bits 3..1 of the data as the component count. A read returns the count in bits 3..1, with bit 0 and all higher bits zero.
- R4: The size word sits at 0x4, with width in bits 31..16 and height in bits 15..0. The low 3 bits of each half are stored as zero, so both dimensions are multiples of 8. The word reads back as stored and drives `imgWidth` and `imgHeight`.
- R5: A control write with data bit 0 set drives `coreStart` high for exactly the cycle in which that write is acknowledged. The start bit itself is never stored.
- R6: The status word sits at 0xC and is read-only. After reset it reads 0 (idle). A start makes it 1 (busy). A `coreDone` pulse while busy makes it 2 (done). A new start makes it 1 again, and `coreDone` outside busy is ignored.
- R7: Quantization entry i sits at 0x100 + 4*i, for i from 0 to 63. A write stores data bits 7..0. A read returns the entry zero-extended. `qVal` shows entry `qIdx` with no clock delay.
- R8: Each byte lane of a write takes effect only when its byte enable is set. The count, the start bit and quantization entries all live in lane 0 (`busBe[0]`).
- R9: A read of any other address, including unaligned offsets inside the table, is acknowledged and returns zero. A write to such an address is acknowledged and changes nothing.
- R10: Reset clears the control, size, status and table state, and leaves `busAck` and `coreStart` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busSel | input | 1 | Access select from the master |
| busRnw | input | 1 | 1 = read, 0 = write |
| busAddr | input | 32 | Byte address |
| busBe | input | 4 | Byte enables for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with acknowledge |
| busAck | output | 1 | One-cycle transfer acknowledge |
| coreDone | input | 1 | Frame-finished pulse from the core |
| coreStart | output | 1 | One-cycle start strobe to the core |
| compCount | output | 3 | Latched component count |
| imgWidth | output | 16 | Image width |
| imgHeight | output | 16 | Image height |
| qIdx | input | 6 | Core table lookup index |
| qVal | output | 8 | Table entry at `qIdx` |

## Verification
The table is filled with a spread of values whose upper data bytes carry junk. Every entry is read back, which separates an address-to-index slip from a failure of the 8-bit truncation. Size words with non-zero low bits expose any missing alignment mask. Control writes with partial byte enables show whether the start bit and the count are tied to lane 0. The status walk covers start, done, a repeated done and a restart, which separates the three status codes from a done that is not gated by busy. Reads of unmapped and unaligned addresses, and a select held high for several cycles, test the decode fallthrough and the single-acknowledge rule.

// File: rtl/encRegPkg.sv
package encRegPkg;

  parameter int QuantDepth = 64;
  localparam int QIdxW = $clog2(QuantDepth);

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_SIZE,
    RD_STAT,
    RD_QUANT
  } rdSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } encStat_e;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrSize;
    logic             wrQuant;
    logic             rdEn;
    rdSel_e           rdSel;
    logic [QIdxW-1:0] qIdx;
  } regStrobe_t;

endpackage

// File: rtl/encRegCtl.sv
module encRegCtl
  import encRegPkg::*;
#(
  parameter int AddrW       = 32,
  parameter int CtrlOffs    = 'h0,
  parameter int SizeOffs    = 'h4,
  parameter int StatOffs    = 'hC,
  parameter int QuantOffs   = 'h100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busSel,
  input  logic             busRnw,
  input  logic [AddrW-1:0] busAddr,
  output logic             busAck,
  output regStrobe_t       strb
);

  localparam int WordB    = 2;
  localparam int QSpanB   = QIdxW + WordB;
  localparam logic [AddrW-1:0] QuantBase = AddrW'(QuantOffs);

  logic selQ;
  logic accessNow;
  logic hitCtrl, hitSize, hitStat, hitQuant;

  // an access starts on the first edge that sees select high
  assign accessNow = busSel & ~selQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      selQ   <= 1'b0;
      busAck <= 1'b0;
    end else begin
      selQ   <= busSel;
      busAck <= accessNow;
    end
  end

  always_comb begin
    hitCtrl  = (busAddr == AddrW'(CtrlOffs));
    hitSize  = (busAddr == AddrW'(SizeOffs));
    hitStat  = (busAddr == AddrW'(StatOffs));
    hitQuant = (busAddr[AddrW-1:QSpanB] == QuantBase[AddrW-1:QSpanB]) &&
               (busAddr[WordB-1:0] == '0);
  end

  always_comb begin
    strb         = '0;
    strb.qIdx    = busAddr[QSpanB-1:WordB];
    strb.rdSel   = RD_NONE;
    if (accessNow) begin
      if (busRnw) begin
        strb.rdEn = 1'b1;
        if (hitCtrl)       strb.rdSel = RD_CTRL;
        else if (hitSize)  strb.rdSel = RD_SIZE;
        else if (hitStat)  strb.rdSel = RD_STAT;
        else if (hitQuant) strb.rdSel = RD_QUANT;
      end else begin
        strb.wrCtrl  = hitCtrl;
        strb.wrSize  = hitSize;
        strb.wrQuant = hitQuant;
      end
    end
  end

  // R1: acknowledge lasts one cycle
  a_r1_single_ack: assert property (@(posedge clk) disable iff (rst)
    busAck |=> !busAck);

  // R1: acknowledge follows a rising select
  a_r1_ack_after_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(busSel) |=> busAck);

  // R1: no acknowledge without a select in the cycle before
  a_r1_ack_needs_sel: assert property (@(posedge clk) disable iff (rst)
    busAck |-> $past(busSel));

endmodule

// File: rtl/encRegData.sv
module encRegData
  import encRegPkg::*;
#(
  parameter int DataW    = 32,
  parameter int CompW    = 3,
  parameter int QuantW   = 8,
  parameter int DimW     = 16,
  parameter int AlignB   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [DataW/8-1:0] busBe,
  input  logic [DataW-1:0]  busWdata,
  input  logic              coreDone,
  input  logic [QIdxW-1:0]  qIdx,
  output logic [DataW-1:0]  busRdata,
  output logic              coreStart,
  output logic [CompW-1:0]  compCount,
  output logic [DimW-1:0]   imgWidth,
  output logic [DimW-1:0]   imgHeight,
  output logic [QuantW-1:0] qVal
);

  localparam int Lanes = DataW / 8;
  localparam logic [DimW-1:0]  DimMask  = ~DimW'((1 << AlignB) - 1);
  localparam logic [DataW-1:0] SizeMask = {DimMask, DimMask};

  logic [DataW-1:0]  sizeReg;
  logic [DataW-1:0]  sizeNext;
  logic [QuantW-1:0] qTab [QuantDepth];
  encStat_e          stat;
  logic              startNow;
  logic [DataW-1:0]  rdMux;

  assign startNow = strb.wrCtrl & busBe[0] & busWdata[0];

  // control: count latch and start strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      compCount <= '0;
      coreStart <= 1'b0;
    end else begin
      coreStart <= startNow;
      if (strb.wrCtrl && busBe[0]) compCount <= busWdata[CompW:1];
    end
  end

  // size word, byte-lane merge then alignment mask
  always_comb begin
    sizeNext = sizeReg;
    for (int b = 0; b < Lanes; b++) begin
      if (busBe[b]) sizeNext[8*b +: 8] = busWdata[8*b +: 8];
    end
    sizeNext = sizeNext & SizeMask;
  end

  always_ff @(posedge clk) begin
    if (rst)              sizeReg <= '0;
    else if (strb.wrSize) sizeReg <= sizeNext;
  end

  assign imgWidth  = sizeReg[2*DimW-1:DimW];
  assign imgHeight = sizeReg[DimW-1:0];

  // quantization table
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < QuantDepth; i++) qTab[i] <= '0;
    end else if (strb.wrQuant && busBe[0]) begin
      qTab[strb.qIdx] <= busWdata[QuantW-1:0];
    end
  end

  assign qVal = qTab[qIdx];

  // status: start takes priority over done
  always_ff @(posedge clk) begin
    if (rst) stat <= ST_IDLE;
    else if (startNow) stat <= ST_BUSY;
    else if (coreDone && stat == ST_BUSY) stat <= ST_DONE;
  end

  always_comb begin
    rdMux = '0;
    case (strb.rdSel)
      RD_CTRL:  rdMux[CompW:1]    = compCount;
      RD_SIZE:  rdMux             = sizeReg;
      RD_STAT:  rdMux[1:0]        = stat;
      RD_QUANT: rdMux[QuantW-1:0] = qTab[strb.qIdx];
      default:  rdMux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) busRdata <= '0;
    else     busRdata <= strb.rdEn ? rdMux : '0;
  end

  // R5: start strobe lasts one cycle
  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    coreStart |=> !coreStart);

  // R6: strobe and busy status appear together
  a_r6_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    coreStart |-> stat == ST_BUSY);

  // R6: done while busy finishes the frame
  a_r6_done_when_busy: assert property (@(posedge clk) disable iff (rst)
    (stat == ST_BUSY && coreDone && !startNow) |=> stat == ST_DONE);

  // R6: idle never jumps to done
  a_r6_idle_not_done: assert property (@(posedge clk) disable iff (rst)
    stat == ST_IDLE |=> stat != ST_DONE);

endmodule

// File: rtl/encRegBank.sv
module encRegBank
  import encRegPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        busSel,
  input  logic        busRnw,
  input  logic [31:0] busAddr,
  input  logic [3:0]  busBe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busAck,
  input  logic        coreDone,
  output logic        coreStart,
  output logic [2:0]  compCount,
  output logic [15:0] imgWidth,
  output logic [15:0] imgHeight,
  input  logic [5:0]  qIdx,
  output logic [7:0]  qVal
);

  regStrobe_t strb;

  encRegCtl #(.AddrW(32)) uCtl (
    .clk    (clk),
    .rst    (rst),
    .busSel (busSel),
    .busRnw (busRnw),
    .busAddr(busAddr),
    .busAck (busAck),
    .strb   (strb)
  );

  encRegData #(.DataW(32), .CompW(3), .QuantW(8), .DimW(16), .AlignB(3)) uData (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .busBe    (busBe),
    .busWdata (busWdata),
    .coreDone (coreDone),
    .qIdx     (qIdx),
    .busRdata (busRdata),
    .coreStart(coreStart),
    .compCount(compCount),
    .imgWidth (imgWidth),
    .imgHeight(imgHeight),
    .qVal     (qVal)
  );

  // R2: read data is quiet outside acknowledge
  a_r2_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
    !busAck |-> busRdata == '0);

endmodule

// File: tb/encRegBank_test.sv
module encRegBank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busRnw = 1'b0;
  logic [31:0] busAddr = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busAck;
  logic        coreDone = 1'b0;
  logic        coreStart;
  logic [2:0]  compCount;
  logic [15:0] imgWidth, imgHeight;
  logic [5:0]  qIdx = '0;
  logic [7:0]  qVal;

  int nCmp = 0;
  int nBad = 0;
  logic [31:0] expQ[$];
  string       reqQ[$];
  logic        startAtAck, startAfter;

  always #4 clk = ~clk;

  encRegBank uut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // monitor: pops expected read data when a read is acknowledged
  always @(negedge clk) begin
    if (!rst && busAck && busRnw) begin
      if (expQ.size() == 0) chk(0, "R2 unexpected read", busRdata, 32'h0);
      else begin
        logic [31:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        chk(busRdata == e, r, busRdata, e);
      end
    end
  end

  task automatic access(input logic [31:0] a, input bit rnw, input logic [3:0] be,
                        input logic [31:0] wd);
    @(posedge clk); #1;
    busSel = 1'b1; busRnw = rnw; busAddr = a; busBe = be; busWdata = wd;
    @(negedge clk);
    chk(busAck == 1'b0, "R1 early ack", 32'(busAck), 32'h0);
    chk(busRdata == 32'h0, "R2 rdata before ack", busRdata, 32'h0);
    @(negedge clk);
    chk(busAck == 1'b1, "R1 ack", 32'(busAck), 32'h1);
    startAtAck = coreStart;
    @(posedge clk); #1;
    busSel = 1'b0; busBe = '0; busWdata = '0; busAddr = '0;
    @(negedge clk);
    chk(busAck == 1'b0, "R1 ack one cycle", 32'(busAck), 32'h0);
    chk(busRdata == 32'h0, "R2 rdata after ack", busRdata, 32'h0);
    startAfter = coreStart;
    busRnw = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    expQ.push_back(exp);
    reqQ.push_back(req);
    access(a, 1'b1, 4'hF, 32'h0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    access(a, 1'b0, be, d);
  endtask

  task automatic pulseDone();
    @(posedge clk); #1 coreDone = 1'b1;
    @(posedge clk); #1 coreDone = 1'b0;
  endtask

  function automatic logic [7:0] qv(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  initial begin
    #800000;
    chk(0, "watchdog", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(busAck == 1'b0, "R10 ack low", 32'(busAck), 32'h0);
    chk(coreStart == 1'b0, "R10 start low", 32'(coreStart), 32'h0);
    chk({imgWidth, imgHeight} == 32'h0, "R10 size zero", {imgWidth, imgHeight}, 32'h0);
    chk(qVal == 8'h0, "R10 table zero", 32'(qVal), 32'h0);
    rd(32'h0, 32'h0, "R10 ctrl reset");
    rd(32'h4, 32'h0, "R10 size reset");
    rd(32'hC, 32'h0, "R10 R6 status idle");

    // R4 size word
    wr(32'h4, 32'h0280_01E0, 4'hF);
    rd(32'h4, 32'h0280_01E0, "R4 size readback");
    chk(imgWidth == 16'd640 && imgHeight == 16'd480, "R4 dims",
        {imgWidth, imgHeight}, 32'h0280_01E0);
    wr(32'h4, 32'h0287_01E5, 4'hF);
    rd(32'h4, 32'h0280_01E0, "R4 alignment mask");
    // R8 lane-selective size write: only lane 3 (width high byte)
    wr(32'h4, 32'h1234_5678, 4'b1000);
    rd(32'h4, 32'h1280_01E0, "R8 size lane 3");

    // R7 table fill with junk in upper bytes
    for (int i = 0; i < 64; i++) wr(32'h100 + 4 * i, {24'hABCDEF, qv(i)}, 4'hF);
    for (int i = 0; i < 64; i++) rd(32'h100 + 4 * i, {24'h0, qv(i)}, "R7 table readback");
    for (int i = 0; i < 64; i += 9) begin
      qIdx = 6'(i); #1;
      chk(qVal == qv(i), "R7 lookup port", 32'(qVal), 32'(qv(i)));
    end
    // R8 table write with lane 0 disabled is ignored
    wr(32'h114, 32'h0000_00FF, 4'b1110);
    rd(32'h114, {24'h0, qv(5)}, "R8 table lane 0");

    // R5 start, R3 count
    wr(32'h0, 32'h7, 4'hF);
    chk(startAtAck == 1'b1, "R5 start at ack", 32'(startAtAck), 32'h1);
    chk(startAfter == 1'b0, "R5 start one cycle", 32'(startAfter), 32'h0);
    chk(compCount == 3'd3, "R3 count out", 32'(compCount), 32'h3);
    rd(32'h0, 32'h6, "R3 R5 ctrl readback");
    rd(32'hC, 32'h1, "R6 busy");

    // R6 done
    pulseDone();
    rd(32'hC, 32'h2, "R6 done");
    pulseDone();
    rd(32'hC, 32'h2, "R6 done stays");
    wr(32'hC, 32'h0, 4'hF);
    rd(32'hC, 32'h2, "R6 status read-only");
    wr(32'h0, 32'h3, 4'hF);
    chk(startAtAck == 1'b1, "R5 restart", 32'(startAtAck), 32'h1);
    rd(32'hC, 32'h1, "R6 restart busy");
    rd(32'h0, 32'h2, "R3 count one");

    // R8 ctrl with lane 0 disabled: no start, count unchanged
    wr(32'h0, 32'hFFFF_FF0F, 4'b1110);
    chk(startAtAck == 1'b0, "R8 no start", 32'(startAtAck), 32'h0);
    rd(32'h0, 32'h2, "R8 count kept");
    // R3 upper data bits are not stored
    wr(32'h0, 32'hFFFF_FF0A, 4'hF);
    chk(startAtAck == 1'b0, "R5 no start bit", 32'(startAtAck), 32'h0);
    rd(32'h0, 32'hA, "R3 upper bits");

    // R9 unmapped
    rd(32'h8, 32'h0, "R9 read 0x8");
    rd(32'h200, 32'h0, "R9 read 0x200");
    rd(32'h102, 32'h0, "R9 read unaligned");
    wr(32'h8, 32'hFFFF_FFFF, 4'hF);
    chk(startAtAck == 1'b0, "R9 no start", 32'(startAtAck), 32'h0);
    wr(32'h106, 32'hFFFF_FFFF, 4'hF);
    rd(32'h0, 32'hA, "R9 ctrl untouched");
    rd(32'h4, 32'h1280_01E0, "R9 size untouched");
    rd(32'h104, {24'h0, qv(1)}, "R9 table untouched");
    rd(32'hC, 32'h1, "R9 status untouched");

    // R1 select held: one acknowledge only
    begin
      int acks;
      acks = 0;
      @(posedge clk); #1;
      busSel = 1'b1; busRnw = 1'b0; busAddr = 32'h8; busBe = 4'hF;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (busAck) acks++;
      end
      @(posedge clk); #1 busSel = 1'b0;
      @(negedge clk);
      if (busAck) acks++;
      chk(acks == 1, "R1 held select", 32'(acks), 32'h1);
    end
    rd(32'h0, 32'hA, "R1 access after hold");

    @(negedge clk);
    chk(expQ.size() == 0, "R2 pending reads", 32'(expQ.size()), 32'h0);
    finishRun();
  end

endmodule